// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Engine

This block walks a circular table of transmit descriptors held in memory and turns each one into a stream of frame bytes. Every descriptor occupies four 32-bit words: a flags word, a byte count, the low half of the buffer address and the high half. The engine reads a descriptor, fetches the buffer it names in bursts of words, and presents the bytes one per beat on a ready/valid stream. Start and end markers on the stream follow the descriptor's flags.

Software sets up the table base, enables the engine and then posts work by moving a stop pointer. The stop pointer holds the byte address just past the last descriptor that is ready. The engine keeps processing until its own current pointer reaches the stop pointer. A flag in a descriptor can send the next fetch back to the table base, which closes the ring. A pause request lets the descriptor in progress finish and then parks the engine. Turning the enable off also waits for that descriptor to finish before the engine reports that it is off. A state field reports which of these conditions holds, and a write-one-to-clear bit flags completed descriptors that asked for an interrupt.

Top module: `txdma_engine`

Register map (word index on `reg_addr`): 0 control, 1 table base low, 2 table base high, 3 stop pointer, 4 status A, 5 status B, 6 interrupt status. Control fields: bit 0 enable, bit 1 pause, bit 11 parity-off, bits 20:18 burst select. Status A: bits 31:28 state, bits 27:0 current pointer. State codes: 0 off, 1 running, 2 parked, 3 halted, 4 pausing. Status B holds the bytes still to send from the current descriptor. Descriptor flags word: bit 31 frame start, bit 30 frame end, bit 29 interrupt request, bit 28 wrap. The byte count sits in bits 15:0 of the second word.

## Requirements
- R1: After reset, status A reports state 0 with pointer 0, the interrupt output is low, no stream beat is valid and control reads back 0.
- R2: Each descriptor is read with one 4-word request at address {table base high, current pointer}, and the words are taken in the order flags, count, address low, address high. A request holds its address and length until granted.
- R3: A descriptor with count N (1 to MAX_LEN) emits exactly N bytes, taken from its buffer lowest byte lane first. The start marker goes on the first byte only when flag bit 31 is set, and the end marker goes on the last byte only when flag bit 30 is set. A stalled beat holds its data and markers.
- R4: The current pointer advances by 16 bytes per descriptor. Once it equals the stop pointer the engine parks (state 2) and issues no more requests.
- R5: When a descriptor has flag bit 28 set, the next pointer is the table base instead of pointer+16.
- R6: A descriptor with count 0 emits no bytes and issues no buffer read, but the pointer still advances.
- R7: Setting the pause bit while a descriptor is streaming reports state 4 until that descriptor completes. The engine then reports state 2 with the pointer one step on and fetches nothing more. Clearing the pause bit resumes the walk.
- R8: Clearing enable during a descriptor keeps state 1 until that descriptor completes. State 0 follows, with the pointer one step on, and no request or beat occurs while the state is 0.
- R9: Setting enable again resets the current pointer to the table base.
- R10: Completing a descriptor with flag bit 29 sets interrupt status bit 0 and the interrupt output. Writing 1 to bit 0 of register 6 clears it, and descriptors without the flag leave it clear.
- R11: The parity-off control bit reads back as written.
- R12: Buffer reads use requests of min(2^B, remaining words) words, where B is control bits 20:18. The address advances by 4 bytes per word.
- R13: A descriptor with count above MAX_LEN emits nothing and halts the engine in state 3 until enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Request byte address |
| mem_words | output | 8 | Request length in 32-bit words |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 32 | Read word |
| mem_rready | output | 1 | Engine accepts a read word |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream beat valid |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Sink accepts the beat |
| tx_irq | output | 1 | Completion interrupt status |

## Verification
The hardest situations to reach are a pause or disable request that lands in the middle of a descriptor. If the request arrives between descriptors, a broken drain rule looks exactly like a correct one. The bench therefore holds the stream sink not ready, posts work, waits until a beat is pending and only then writes the control register. This pins the engine inside a descriptor while the reported state and pointer are read. Random rounds with random burst selects, zero and odd byte counts, and stop pointers that wrap through the table's wrap flag cover the ring walk around them.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  typedef enum logic [3:0] {
    ST_OFF      = 4'd0,
    ST_RUN      = 4'd1,
    ST_PARKED   = 4'd2,
    ST_HALTED   = 4'd3,
    ST_PAUSING  = 4'd4
  } dma_state_e;

  typedef enum logic [3:0] {
    W_OFF, W_WAIT, W_DREQ, W_DRD, W_DCHK,
    W_BREQ, W_BRD, W_EMIT, W_DONE, W_HALT
  } walk_e;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_BASEL = 3'd1;
  localparam logic [2:0] RA_BASEH = 3'd2;
  localparam logic [2:0] RA_STOP  = 3'd3;
  localparam logic [2:0] RA_STATA = 3'd4;
  localparam logic [2:0] RA_STATB = 3'd5;
  localparam logic [2:0] RA_IRQ   = 3'd6;

  localparam int CB_EN   = 0;
  localparam int CB_PAUS = 1;
  localparam int CB_POFF = 11;
  localparam int CB_BSEL = 18;

  // flags nibble taken from descriptor word 0 bits 31:28
  localparam int FL_SOF  = 3;
  localparam int FL_EOF  = 2;
  localparam int FL_IRQ  = 1;
  localparam int FL_WRAP = 0;

endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
  import txdma_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter bit PARITY_OK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [31:0]      cur_ptr,
  input  dma_state_e       state,
  input  logic [CNT_W-1:0] remain,
  input  logic             irq_set,
  output logic             en,
  output logic             pause,
  output logic [2:0]       bsel,
  output logic [31:0]      base_lo,
  output logic [31:0]      base_hi,
  output logic [31:0]      stop_ptr,
  output logic             irq
);

  logic        en_n, pause_n, poff_q, poff_n, irq_n;
  logic [2:0]  bsel_n;
  logic [31:0] base_lo_n, base_hi_n, stop_n;
  logic        wr_ctrl;

  assign wr_ctrl = wr && (addr == RA_CTRL);

  always_comb begin
    en_n      = en;
    pause_n   = pause;
    bsel_n    = bsel;
    base_lo_n = base_lo;
    base_hi_n = base_hi;
    stop_n    = stop_ptr;
    irq_n     = irq;
    if (wr_ctrl) begin
      en_n    = wdata[CB_EN];
      pause_n = wdata[CB_PAUS];
      bsel_n  = wdata[CB_BSEL +: 3];
    end
    if (wr && addr == RA_BASEL) base_lo_n = {wdata[31:4], 4'h0};
    if (wr && addr == RA_BASEH) base_hi_n = wdata;
    if (wr && addr == RA_STOP)  stop_n    = {wdata[31:4], 4'h0};
    if (wr && addr == RA_IRQ && wdata[0]) irq_n = 1'b0;
    if (irq_set) irq_n = 1'b1;
  end

  generate
    if (PARITY_OK) begin : g_par
      assign poff_n = wr_ctrl ? wdata[CB_POFF] : poff_q;
      AST_POFF_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> poff_q == $past(wdata[CB_POFF])); // R11
    end else begin : g_nopar
      assign poff_n = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      pause    <= 1'b0;
      poff_q   <= 1'b0;
      bsel     <= 3'd0;
      base_lo  <= 32'd0;
      base_hi  <= 32'd0;
      stop_ptr <= 32'd0;
      irq      <= 1'b0;
    end else begin
      en       <= en_n;
      pause    <= pause_n;
      poff_q   <= poff_n;
      bsel     <= bsel_n;
      base_lo  <= base_lo_n;
      base_hi  <= base_hi_n;
      stop_ptr <= stop_n;
      irq      <= irq_n;
    end
  end

  always_comb begin
    rdata = 32'd0;
    case (addr)
      RA_CTRL:  rdata = {11'd0, bsel, 6'd0, poff_q, 9'd0, pause, en};
      RA_BASEL: rdata = base_lo;
      RA_BASEH: rdata = base_hi;
      RA_STOP:  rdata = stop_ptr;
      RA_STATA: rdata = {state, cur_ptr[27:0]};
      RA_STATB: rdata = {{(32-CNT_W){1'b0}}, remain};
      RA_IRQ:   rdata = {31'd0, irq};
      default:  rdata = 32'd0;
    endcase
  end

  AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq); // R10
  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RA_IRQ && wdata[0] && !irq_set) |=> !irq); // R10

endmodule

// File: rtl/txdma_walker.sv
module txdma_walker
  import txdma_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_LEN = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pause,
  input  logic [2:0]       bsel,
  input  logic [31:0]      base_lo,
  input  logic [31:0]      base_hi,
  input  logic [31:0]      stop_ptr,
  output logic             mem_req,
  output logic [63:0]      mem_addr,
  output logic [7:0]       mem_words,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             mem_rready,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             tx_sof,
  output logic             tx_eof,
  input  logic             tx_ready,
  output logic [31:0]      cur_ptr,
  output dma_state_e       state,
  output logic [CNT_W-1:0] remain,
  output logic             irq_set
);

  walk_e            fsm, fsm_n;
  logic [31:0]      cur_n;
  logic [3:0]       flg, flg_n;
  logic [CNT_W-1:0] cnt, cnt_n, rem_n, wleft, wleft_n;
  logic [63:0]      baddr, baddr_n;
  logic [31:0]      word, word_n;
  logic [7:0]       bcnt, bcnt_n, bmax, burst;
  logic [1:0]       bidx, bidx_n, wsel, wsel_n;
  logic             first, first_n;

  assign bmax  = 8'd1 << bsel;
  assign burst = (wleft < {{(CNT_W-8){1'b0}}, bmax}) ? wleft[7:0] : bmax;

  always_comb begin
    fsm_n = fsm;   cur_n = cur_ptr; flg_n = flg;   cnt_n = cnt;
    rem_n = remain; wleft_n = wleft; baddr_n = baddr; word_n = word;
    bcnt_n = bcnt; bidx_n = bidx;   wsel_n = wsel; first_n = first;
    irq_set = 1'b0; mem_req = 1'b0; mem_addr = 64'd0; mem_words = 8'd0;
    mem_rready = 1'b0; tx_valid = 1'b0; tx_sof = 1'b0; tx_eof = 1'b0;
    tx_data = word[8*bidx +: 8];
    case (fsm)
      W_OFF: if (en) begin
        cur_n = base_lo;
        fsm_n = W_WAIT;
      end
      W_WAIT: begin
        if (!en) fsm_n = W_OFF;
        else if (!pause && cur_ptr != stop_ptr) fsm_n = W_DREQ;
      end
      W_DREQ: begin
        mem_req   = 1'b1;
        mem_addr  = {base_hi, cur_ptr};
        mem_words = 8'd4;
        if (mem_gnt) begin
          fsm_n  = W_DRD;
          wsel_n = 2'd0;
        end
      end
      W_DRD: begin
        mem_rready = 1'b1;
        if (mem_rvalid) begin
          case (wsel)
            2'd0: flg_n = mem_rdata[31:28];
            2'd1: cnt_n = mem_rdata[CNT_W-1:0];
            2'd2: baddr_n[31:0] = mem_rdata;
            default: baddr_n[63:32] = mem_rdata;
          endcase
          wsel_n = wsel + 2'd1;
          if (wsel == 2'd3) fsm_n = W_DCHK;
        end
      end
      W_DCHK: begin
        rem_n   = cnt;
        first_n = 1'b1;
        wleft_n = CNT_W'(({1'b0, cnt} + (CNT_W+1)'(3)) >> 2);
        if (cnt == '0) fsm_n = W_DONE;
        else if (cnt > CNT_W'(MAX_LEN)) fsm_n = W_HALT;
        else fsm_n = W_BREQ;
      end
      W_BREQ: begin
        mem_req   = 1'b1;
        mem_addr  = baddr;
        mem_words = burst;
        if (mem_gnt) begin
          baddr_n = baddr + {54'd0, burst, 2'b00};
          wleft_n = wleft - {{(CNT_W-8){1'b0}}, burst};
          bcnt_n  = burst;
          fsm_n   = W_BRD;
        end
      end
      W_BRD: begin
        mem_rready = 1'b1;
        if (mem_rvalid) begin
          word_n = mem_rdata;
          bidx_n = 2'd0;
          bcnt_n = bcnt - 8'd1;
          fsm_n  = W_EMIT;
        end
      end
      W_EMIT: begin
        tx_valid = 1'b1;
        tx_sof   = first && flg[FL_SOF];
        tx_eof   = (remain == CNT_W'(1)) && flg[FL_EOF];
        if (tx_ready) begin
          rem_n   = remain - CNT_W'(1);
          first_n = 1'b0;
          bidx_n  = bidx + 2'd1;
          if (remain == CNT_W'(1)) fsm_n = W_DONE;
          else if (bidx == 2'd3) fsm_n = (bcnt != 8'd0) ? W_BRD : W_BREQ;
        end
      end
      W_DONE: begin
        irq_set = flg[FL_IRQ];
        cur_n   = flg[FL_WRAP] ? base_lo : cur_ptr + 32'd16;
        fsm_n   = en ? W_WAIT : W_OFF;
      end
      W_HALT: if (!en) fsm_n = W_OFF;
      default: fsm_n = W_OFF;
    endcase
  end

  always_comb begin
    case (fsm)
      W_OFF:   state = ST_OFF;
      W_HALT:  state = ST_HALTED;
      W_WAIT:  state = (!en || pause || cur_ptr == stop_ptr) ? ST_PARKED : ST_RUN;
      default: state = pause ? ST_PAUSING : ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm <= W_OFF;   cur_ptr <= 32'd0; flg <= 4'd0;   cnt <= '0;
      remain <= '0;   wleft <= '0;      baddr <= 64'd0; word <= 32'd0;
      bcnt <= 8'd0;   bidx <= 2'd0;     wsel <= 2'd0;  first <= 1'b0;
    end else begin
      fsm <= fsm_n;   cur_ptr <= cur_n; flg <= flg_n;  cnt <= cnt_n;
      remain <= rem_n; wleft <= wleft_n; baddr <= baddr_n; word <= word_n;
      bcnt <= bcnt_n; bidx <= bidx_n;   wsel <= wsel_n; first <= first_n;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_words))); // R2
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof))); // R3
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && fsm == W_BREQ) |-> (mem_words != 8'd0 && mem_words <= bmax)); // R12
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF) |-> (!tx_valid && !mem_req)); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALTED) |-> (!tx_valid && !mem_req)); // R13

endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
  import txdma_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_LEN   = 2048,
  parameter bit PARITY_OK = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_words,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        mem_rready,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_sof,
  output logic        tx_eof,
  input  logic        tx_ready,
  output logic        tx_irq
);

  logic             en, pause, irq_set;
  logic [2:0]       bsel;
  logic [31:0]      base_lo, base_hi, stop_ptr, cur_ptr;
  logic [CNT_W-1:0] remain;
  dma_state_e       state;

  txdma_regs #(.CNT_W(CNT_W), .PARITY_OK(PARITY_OK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .cur_ptr(cur_ptr), .state(state), .remain(remain),
    .irq_set(irq_set), .en(en), .pause(pause), .bsel(bsel), .base_lo(base_lo),
    .base_hi(base_hi), .stop_ptr(stop_ptr), .irq(tx_irq)
  );

  txdma_walker #(.CNT_W(CNT_W), .MAX_LEN(MAX_LEN)) u_walk (
    .clk(clk), .rst_n(rst_n), .en(en), .pause(pause), .bsel(bsel),
    .base_lo(base_lo), .base_hi(base_hi), .stop_ptr(stop_ptr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_words(mem_words),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_rready(mem_rready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_ready(tx_ready),
    .cur_ptr(cur_ptr), .state(state), .remain(remain), .irq_set(irq_set)
  );

endmodule

// File: tb/txdma_engine_test.sv
`timescale 1ns/1ps
module txdma_engine_test;

  localparam int MAXL = 2048;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic mem_req, mem_gnt, mem_rvalid, mem_rready;
  logic [63:0] mem_addr;
  logic [7:0] mem_words;
  logic [31:0] mem_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_sof, tx_eof, tx_ready, tx_irq;

  always #2.5 clk = ~clk;

  txdma_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_words(mem_words), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rready(mem_rready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .tx_ready(tx_ready), .tx_irq(tx_irq)
  );

  int checks = 0, fails = 0;
  logic [31:0] mem [0:511];
  bit hold_rdy = 1'b0;
  logic [9:0] cap_q[$], exp_q[$];
  logic [71:0] obs_rq[$], exp_rq[$];
  bit exp_irq;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // memory model and stream sink
  initial begin
    logic [63:0] ra, ga; int rl; logic [7:0] gw; bit g, d;
    rl = 0; ra = 0;
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = 0; tx_ready = 0;
    forever begin
      @(posedge clk);
      g = mem_req && mem_gnt; d = mem_rvalid && mem_rready;
      ga = mem_addr; gw = mem_words;
      if (tx_valid && tx_ready) cap_q.push_back({tx_sof, tx_eof, tx_data});
      @(negedge clk);
      if (g) begin ra = ga; rl = gw; obs_rq.push_back({gw, ga}); end
      if (d) begin ra = ra + 4; rl = rl - 1; end
      if (rl != 0) begin
        mem_gnt = 0; mem_rvalid = ($urandom % 4 != 0); mem_rdata = mem[ra[10:2]];
      end else begin
        mem_rvalid = 0; mem_gnt = mem_req && ($urandom % 2 == 1);
      end
      tx_ready = hold_rdy ? 1'b0 : ($urandom % 4 != 0);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit ps, input int bl);
    return {11'd0, 3'(bl), 6'd0, 1'b0, 9'd0, ps, en};
  endfunction

  task automatic set_desc(input int i, input logic [3:0] fl, input int cnt);
    mem[64+4*i] = {fl, 28'd0};
    mem[65+4*i] = cnt;
    mem[66+4*i] = 32'h200 + 32'h40 * i;
    mem[67+4*i] = 0;
    for (int w = 0; w < 16; w++) mem[128+16*i+w] = $urandom;
  endtask

  task automatic build_exp(input logic [31:0] from_p, input logic [31:0] to_p, input int bl);
    logic [31:0] p, a; logic [3:0] fl; int cnt, wl, b, g; logic [31:0] w;
    p = from_p; g = 0;
    while (p != to_p && g < 16) begin
      fl = mem[p[10:2]][31:28]; cnt = mem[p[10:2]+1][15:0]; a = mem[p[10:2]+2];
      exp_rq.push_back({8'd4, 32'd1, p});
      if (cnt != 0 && cnt <= MAXL) begin
        wl = (cnt + 3) / 4;
        while (wl > 0) begin
          b = (wl < (1 << bl)) ? wl : (1 << bl);
          exp_rq.push_back({8'(b), 32'd0, a});
          a = a + 4*b; wl = wl - b;
        end
        a = mem[p[10:2]+2];
        for (int j = 0; j < cnt; j++) begin
          w = mem[9'((a + j) >> 2)];
          exp_q.push_back({(j == 0) && fl[3], (j == cnt-1) && fl[2], w[8*(j%4) +: 8]});
        end
      end
      if (fl[1]) exp_irq = 1;
      p = fl[0] ? BASE : p + 16; g++;
    end
  endtask

  task automatic clear_logs();
    cap_q.delete(); exp_q.delete(); obs_rq.delete(); exp_rq.delete();
  endtask

  task automatic cmp_run(input string tag);
    int bad;
    chk(cap_q.size() == exp_q.size(), {"R3 byte count ", tag}, cap_q.size(), exp_q.size());
    bad = 0;
    foreach (exp_q[i]) if (i < cap_q.size() && cap_q[i] !== exp_q[i]) bad++;
    chk(bad == 0, {"R3 byte/marker mismatches ", tag}, bad, 0);
    chk(obs_rq.size() == exp_rq.size(), {"R2/R12 request count ", tag}, obs_rq.size(), exp_rq.size());
    bad = 0;
    foreach (exp_rq[i]) if (i < obs_rq.size() && obs_rq[i] !== exp_rq[i]) bad++;
    chk(bad == 0, {"R2/R12 request mismatches ", tag}, bad, 0);
  endtask

  task automatic wait_state(input logic [3:0] st, input logic [31:0] ptr, input bit use_ptr, input string rq);
    logic [31:0] v; int n;
    n = 0;
    do begin rd(3'd4, v); n++; end
    while (!(v[31:28] == st && (!use_ptr || v[27:0] == ptr[27:0])) && n < 6000);
    chk(n < 6000, {rq, " state wait timeout"}, v, {st, ptr[27:0]});
  endtask

  task automatic wait_beat();
    int n;
    n = 0;
    while (!tx_valid && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v; int bl, k1, k2;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(3'd4, v); chk(v == 32'd0, "R1 status A after reset", v, 0);
    rd(3'd0, v); chk(v == 32'd0, "R1 control after reset", v, 0);
    chk(!tx_irq && !tx_valid && !mem_req, "R1 outputs idle", {tx_irq, tx_valid, mem_req}, 0);

    // R11 parity-off readback
    wr(3'd0, 32'h0000_0800); rd(3'd0, v);
    chk(v[11] == 1'b1, "R11 parity-off set", v[11], 1);
    wr(3'd0, 32'd0); rd(3'd0, v);
    chk(v[11] == 1'b0, "R11 parity-off cleared", v[11], 0);

    // directed ring: R2 R3 R4 R6 R10
    set_desc(0, 4'b1100, 1 + $urandom % 64);
    set_desc(1, 4'b1100, 5);
    set_desc(2, 4'b1110, 0);
    set_desc(3, 4'b1110, 64);
    set_desc(4, 4'b1100, 1 + $urandom % 64);
    set_desc(5, 4'b1101, 1 + $urandom % 64);
    wr(3'd1, BASE); wr(3'd2, 32'd1);
    clear_logs(); exp_irq = 0;
    wr(3'd0, ctl(1, 0, 1));
    rd(3'd4, v); chk(v[27:0] == BASE[27:0], "R9 pointer at base after enable", v[27:0], BASE);
    build_exp(BASE, BASE + 32'h40, 1);
    wr(3'd3, BASE + 32'h40);
    wait_state(4'd2, BASE + 32'h40, 1, "R4");
    repeat (20) @(negedge clk);
    cmp_run("ring first post");
    begin
      int hits; hits = 0;
      foreach (obs_rq[i]) if (obs_rq[i][31:0] >= 32'h280 && obs_rq[i][31:0] < 32'h2C0) hits++;
      chk(hits == 0, "R6 no buffer read for zero count", hits, 0);
    end
    chk(tx_irq == 1'b1, "R10 irq after flagged descriptor", tx_irq, 1);
    wr(3'd6, 32'd1);
    rd(3'd6, v); chk(v[0] == 1'b0 && !tx_irq, "R10 write-one clears irq", v, 0);

    // R5 wrap
    clear_logs(); exp_irq = 0;
    build_exp(BASE + 32'h40, BASE + 32'h10, 1);
    wr(3'd3, BASE + 32'h10);
    wait_state(4'd2, BASE + 32'h10, 1, "R5");
    repeat (20) @(negedge clk);
    cmp_run("R5 wrap");
    chk(tx_irq == 1'b0, "R10 no irq without flag", tx_irq, 0);

    // R7 pause mid-descriptor
    set_desc(1, 4'b1100, 64);
    set_desc(2, 4'b1100, 40);
    clear_logs();
    build_exp(BASE + 32'h10, BASE + 32'h30, 1);
    hold_rdy = 1;
    wr(3'd3, BASE + 32'h30);
    wait_beat();
    wr(3'd0, ctl(1, 1, 1));
    rd(3'd4, v); chk(v[31:28] == 4'd4, "R7 pausing while streaming", v[31:28], 4);
    hold_rdy = 0;
    wait_state(4'd2, BASE + 32'h20, 1, "R7");
    repeat (60) @(negedge clk);
    rd(3'd4, v); chk(v[27:0] == 28'h120, "R7 parked one step on", v[27:0], 32'h120);
    chk(cap_q.size() == 64, "R7 only current descriptor sent", cap_q.size(), 64);
    chk(obs_rq.size() == 9, "R7 no fetch while paused", obs_rq.size(), 9);
    wr(3'd0, ctl(1, 0, 1));
    wait_state(4'd2, BASE + 32'h30, 1, "R7");
    repeat (20) @(negedge clk);
    cmp_run("R7 resume");

    // R8 disable mid-descriptor, R9 re-enable
    clear_logs();
    build_exp(BASE + 32'h30, BASE + 32'h40, 1);
    hold_rdy = 1;
    wr(3'd3, BASE + 32'h50);
    wait_beat();
    wr(3'd0, ctl(0, 0, 1));
    rd(3'd4, v); chk(v[31:28] == 4'd1, "R8 still running while draining", v[31:28], 1);
    hold_rdy = 0;
    wait_state(4'd0, 32'd0, 0, "R8");
    rd(3'd4, v); chk(v[27:0] == 28'h140, "R8 off after one descriptor", v[27:0], 32'h140);
    repeat (20) @(negedge clk);
    cmp_run("R8 drain");
    clear_logs();
    build_exp(BASE, BASE + 32'h50, 1);
    wr(3'd0, ctl(1, 0, 1));
    rd(3'd4, v); chk(v[27:0] == BASE[27:0], "R9 pointer reset on re-enable", v[27:0], BASE);
    wait_state(4'd2, BASE + 32'h50, 1, "R9");
    repeat (20) @(negedge clk);
    cmp_run("R9 rerun");
    wr(3'd6, 32'd1);

    // R13 oversize halts
    wr(3'd0, ctl(0, 0, 1));
    set_desc(0, 4'b1110, MAXL + 1);
    wr(3'd3, BASE + 32'h10);
    clear_logs();
    wr(3'd0, ctl(1, 0, 1));
    wait_state(4'd3, 32'd0, 0, "R13");
    repeat (20) @(negedge clk);
    chk(cap_q.size() == 0, "R13 no bytes on oversize", cap_q.size(), 0);
    chk(obs_rq.size() == 1, "R13 only descriptor read", obs_rq.size(), 1);
    chk(tx_irq == 1'b0, "R13 no completion irq", tx_irq, 0);
    wr(3'd0, ctl(0, 0, 1));
    rd(3'd4, v); chk(v[31:28] == 4'd0, "R13 leaves halt on disable", v[31:28], 0);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      bl = $urandom % 4;
      for (int i = 0; i < 6; i++)
        set_desc(i, {2'($urandom), 1'($urandom), i == 5}, ($urandom % 5 == 0) ? 0 : 1 + $urandom % 64);
      wr(3'd0, ctl(0, 0, bl));
      wr(3'd6, 32'd1);
      k1 = 1 + $urandom % 5; k2 = $urandom % 6;
      clear_logs(); exp_irq = 0;
      wr(3'd3, BASE + 16*k1);
      build_exp(BASE, BASE + 16*k1, bl);
      build_exp(BASE + 16*k1, BASE + 16*k2, bl);
      wr(3'd0, ctl(1, 0, bl));
      wait_state(4'd2, BASE + 16*k1, 1, "R4");
      wr(3'd3, BASE + 16*k2);
      wait_state(4'd2, BASE + 16*k2, 1, "R5");
      repeat (20) @(negedge clk);
      cmp_run("random round");
      chk(tx_irq == exp_irq, "R10 random irq", tx_irq, exp_irq);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule